// File: doc/BRIEF.md
# Floating-Point Status Register with Exception Tracking

This block keeps the floating-point status and control word next to an arithmetic unit. Each time the unit finishes an operation, it presents a completion strobe and a five-bit exception vector. The block then replaces the per-operation cause field with that vector and ORs the vector into a sticky flag field. When a cause bit meets a set enable bit, the block raises a one-cycle trap request that carries a fixed event code. An approximate operation, such as a reciprocal square root estimate, can ask for inexact to be reported. This request takes effect only when the unit reported nothing else.

Software writes the word through a mask of writable bits and reads it back on a registered read port. The block also decodes two controls from the stored word and drives them to the arithmetic unit: truncating rounding and flushing of denormal values. Field layout: rounding mode in bits 1:0, flags in 6:2, enables in 11:7, causes in 16:12, and denormal flush in bit 18. Bit 17 and bits 31:19 are not implemented. Inside each five-bit field, and in the exception vector, bit 4 is invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow and bit 0 inexact.

Top module: `fpu_status_tracker`

## Requirements
- R1: After reset the word reads 0, trap_req is 0, rnd_trunc is 0 and flush_denorm is 0.
- R2: An operation (op_done=1) clears the cause field (bits 16:12) and then loads it with the effective exception vector. The vector bit order is invalid=4, divide-by-zero=3, overflow=2, underflow=1, inexact=0.
- R3: The flag field (bits 6:2) keeps its value and gains the OR of each effective exception vector. Only a software write can clear a flag.
- R4: When an operation's effective vector ANDed with the enable field (bits 11:7) is nonzero, trap_req is 1 for exactly the cycle in which the updated word is visible, and trap_code is 0x120. Otherwise trap_req is 0 and trap_code is 0.
- R5: Only the current operation's causes can trap. Set flags combined with set enables cause no trap after an operation that reports no enabled exception.
- R6: A write (wr_en=1) stores wr_data ANDed with 0x0005FFFF. Bit 17 and bits 31:19 always read 0.
- R7: rnd_trunc is 1 exactly when the rounding field (bits 1:0) holds 01. The encodings 00, 10 and 11 select round-to-nearest-even (rnd_trunc=0).
- R8: flush_denorm equals bit 18 of the stored word.
- R9: When op_approx=1, inexact is added to the effective vector only if op_exc is all zero. Otherwise the effective vector is op_exc unchanged.
- R10: An operation with an all-zero effective vector still clears the cause field, leaves the flags unchanged and raises no trap.
- R11: When a write and an operation occur in the same cycle, the operation update is applied on top of the masked write data. The trap uses the enables from the written data.
- R12: Every result is registered. Read data, trap outputs and mode outputs all change together, one clock edge after the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Stored status word |
| op_done | input | 1 | Operation-complete strobe |
| op_exc | input | 5 | Exception vector from the arithmetic unit |
| op_approx | input | 1 | Operation is approximate (request inexact) |
| trap_req | output | 1 | Trap request pulse |
| trap_code | output | 12 | Trap event code, 0x120 when trap_req is 1 |
| rnd_trunc | output | 1 | Arithmetic unit rounds toward zero |
| flush_denorm | output | 1 | Arithmetic unit flushes denormals to zero |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. This covers the stored word, the trap pulse and both mode outputs. The bench drives inputs on the falling edge and compares all outputs shortly after the next rising edge. On the following cycle it drops the strobes and checks that the trap pulse has ended. The sweep covers all 32 exception vectors, with and without the approximate request, under several enable masks. It also covers every rounding encoding and the case of a write and an operation in the same cycle.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int NEXC     = 5;
  localparam int RM_W     = 2;
  localparam int RM_LO    = 0;
  localparam int FLAG_LO  = 2;
  localparam int EN_LO    = 7;
  localparam int CAUSE_LO = 12;
  localparam int DN_BIT   = 18;
  localparam logic [RM_W-1:0] RM_TOWARD_ZERO = 2'b01;

  function automatic logic [NEXC-1:0] get_field(input logic [31:0] w, input int lo);
    return w[lo +: NEXC];
  endfunction
endpackage

// File: rtl/fpsr_excmap.sv
module fpsr_excmap
  import fpsr_pkg::*;
(
  input  logic            approx,
  input  logic [NEXC-1:0] exc_in,
  output logic [NEXC-1:0] exc_eff
);
  always_comb begin
    exc_eff = exc_in;
    if (approx && (exc_in == '0))
      exc_eff = {{(NEXC-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/fpsr_regfile.sv
module fpsr_regfile
  import fpsr_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [DW-1:0] WMASK = 32'h0005_FFFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            op,
  input  logic [NEXC-1:0] exc,
  output logic [DW-1:0]   word_q,
  output logic [DW-1:0]   word_d,
  output logic            hit
);
  logic [DW-1:0] base;

  always_comb begin
    base   = wr_en ? (wr_data & WMASK) : word_q;
    word_d = base;
    hit    = 1'b0;
    if (op) begin
      word_d[CAUSE_LO +: NEXC] = exc;
      word_d[FLAG_LO  +: NEXC] = base[FLAG_LO +: NEXC] | exc;
      hit = |(exc & base[EN_LO +: NEXC]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_d & WMASK;
  end
endmodule

// File: rtl/fpsr_trapgen.sv
module fpsr_trapgen #(
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] CODE = 12'h120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  output logic              req,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      code <= '0;
    end else begin
      req  <= hit;
      code <= hit ? CODE : '0;
    end
  end
endmodule

// File: rtl/fpsr_modedec.sv
module fpsr_modedec
  import fpsr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] word_d,
  output logic          trunc,
  output logic          flush
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trunc <= 1'b0;
      flush <= 1'b0;
    end else begin
      trunc <= (word_d[RM_LO +: RM_W] == RM_TOWARD_ZERO);
      flush <= word_d[DN_BIT];
    end
  end
endmodule

// File: rtl/fpu_status_tracker.sv
module fpu_status_tracker
  import fpsr_pkg::*;
#(
  parameter int DW = 32,
  parameter int CODE_W = 12,
  parameter logic [DW-1:0] WMASK = 32'h0005_FFFF,
  parameter logic [CODE_W-1:0] TRAP_CODE = 12'h120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic              op_done,
  input  logic [NEXC-1:0]   op_exc,
  input  logic              op_approx,
  output logic              trap_req,
  output logic [CODE_W-1:0] trap_code,
  output logic              rnd_trunc,
  output logic              flush_denorm
);
  logic [NEXC-1:0] exc_eff;
  logic [DW-1:0]   word_q, word_d;
  logic            hit;

  fpsr_excmap u_excmap (
    .approx (op_approx), .exc_in (op_exc), .exc_eff (exc_eff)
  );

  fpsr_regfile #(.DW(DW), .WMASK(WMASK)) u_reg (
    .clk, .rst, .wr_en, .wr_data, .op (op_done), .exc (exc_eff),
    .word_q, .word_d, .hit
  );

  fpsr_trapgen #(.CODE_W(CODE_W), .CODE(TRAP_CODE)) u_trap (
    .clk, .rst, .hit, .req (trap_req), .code (trap_code)
  );

  fpsr_modedec #(.DW(DW)) u_mode (
    .clk, .rst, .word_d (word_d & WMASK), .trunc (rnd_trunc), .flush (flush_denorm)
  );

  assign rd_data = word_q;
endmodule

// File: rtl/fpu_status_tracker_chk.sv
module fpu_status_tracker_chk
  import fpsr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        op_done,
  input logic [4:0]  op_exc,
  input logic        op_approx,
  input logic [31:0] rd_data,
  input logic        trap_req,
  input logic [11:0] trap_code
);
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  // R4
  trap_follows_op_chk: assert property (@(posedge clk) disable iff (rst)
    live && trap_req |-> $past(op_done));

  // R4
  trap_code_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> trap_code == 12'h120);

  // R3
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    live && !$past(wr_en) |->
      ((rd_data[FLAG_LO +: NEXC] & $past(rd_data[FLAG_LO +: NEXC])) == $past(rd_data[FLAG_LO +: NEXC])));

  // R10
  cause_clear_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(op_done) && $past(op_exc) == 5'd0 && !$past(op_approx) |->
      rd_data[CAUSE_LO +: NEXC] == 5'd0 && !trap_req);

  // R6
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:19] == '0 && !rd_data[17]);
endmodule

bind fpu_status_tracker fpu_status_tracker_chk u_chk (
  .clk, .rst, .wr_en, .op_done, .op_exc, .op_approx,
  .rd_data, .trap_req, .trap_code
);

// File: tb/fpu_status_tracker_test.sv
module fpu_status_tracker_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        op_done = 0;
  logic [4:0]  op_exc = 0;
  logic        op_approx = 0;
  logic        trap_req;
  logic [11:0] trap_code;
  logic        rnd_trunc, flush_denorm;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mdl = 0;
  logic        mdl_trap = 0;

  always #5 clk = ~clk;

  fpu_status_tracker uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compute model for a cycle
  task automatic model(input logic w, input logic [31:0] wd, input logic o,
                       input logic [4:0] e, input logic a);
    logic [31:0] b;
    logic [4:0]  ee;
    b  = w ? (wd & 32'h0005_FFFF) : mdl;
    ee = (a && e == 0) ? 5'b00001 : e;
    mdl_trap = 0;
    if (o) begin
      mdl_trap = (ee & b[11:7]) != 0;
      b[16:12] = ee;
      b[6:2]   = b[6:2] | ee;
    end
    mdl = b;
  endtask

  task automatic cyc(input string req, input logic w, input logic [31:0] wd,
                     input logic o, input logic [4:0] e, input logic a);
    @(negedge clk);
    wr_en = w; wr_data = wd; op_done = o; op_exc = e; op_approx = a;
    model(w, wd, o, e, a);
    @(posedge clk); #1;
    chk(req, rd_data, mdl);
    chk(req, {31'd0, trap_req}, {31'd0, mdl_trap});
    chk(req, {20'd0, trap_code}, mdl_trap ? 32'h120 : 32'h0);
    chk("R7", {31'd0, rnd_trunc}, {31'd0, mdl[1:0] == 2'b01});
    chk("R8", {31'd0, flush_denorm}, {31'd0, mdl[18]});
    @(negedge clk);
    wr_en = 0; op_done = 0; op_approx = 0; op_exc = 0;
    @(posedge clk); #1;
    chk("R4 pulse", {31'd0, trap_req}, 32'd0);
  endtask

  initial begin : wd
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", rd_data, 0);
    chk("R1", {31'd0, trap_req}, 0);
    chk("R1", {30'd0, rnd_trunc, flush_denorm}, 0);
    @(negedge clk); rst = 0;

    // R6 mask
    cyc("R6", 1, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R6", 1, 32'h0000_0000, 0, 0, 0);
    // R7 rounding encodings, R8 denorm
    for (int rm = 0; rm < 4; rm++) begin
      cyc("R7", 1, 32'(rm), 0, 0, 0);
      cyc("R8", 1, 32'(rm) | 32'h0004_0000, 0, 0, 0);
    end

    // R2 R3 R4 R9 sweep over enables, vectors, approx
    for (int en = 0; en < 32; en += 5) begin
      cyc("R3 clear", 1, 32'(en) << 7, 0, 0, 0);
      for (int a = 0; a < 2; a++)
        for (int e = 0; e < 32; e++)
          cyc(a ? "R9" : "R2", 0, 0, 1, 5'(e), 1'(a));
    end

    // R5: flags and enables all set, op with no exception
    cyc("R5", 1, 32'h0000_0FFC, 0, 0, 0);
    cyc("R5", 0, 0, 1, 0, 0);
    // R10: cause cleared, flags kept
    cyc("R10", 0, 0, 1, 5'b10000, 0);
    cyc("R10", 0, 0, 1, 0, 0);
    // R11: write and op in the same cycle
    cyc("R11", 1, 32'h0000_0080, 1, 5'b00001, 0);
    cyc("R11", 1, 32'h0000_0000, 1, 5'b00001, 0);
    cyc("R11", 1, 32'h0001_F07C, 1, 5'b00010, 1);
    // R12: back-to-back operations each trap
    cyc("R12", 1, 32'h0000_0F80, 0, 0, 0);
    cyc("R12", 0, 0, 1, 5'b01000, 0);
    cyc("R12", 0, 0, 1, 5'b00100, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule